// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt sources that belong to each processor core and turns them into that core's interrupt pin vector. Every core owns seven local sources: five hardware sources (watchdog, compare, timer, performance counter, debug channel) that latch a pending bit from a one-cycle input pulse, and two software interrupts whose pending bits software sets and clears through a register. A source reaches a pin only when all of these hold: it is pending, it is unmasked, it is routable per the core's control register, and its pin-map register is enabled with a pin number in range. Each core also gets the index of its lowest-numbered pending and unmasked source, which lets a handler dispatch without scanning.

Software reaches the registers over a simple single-cycle bus. Each access carries the index of the accessing core. Address bit 5 picks the window. The local window (bit 5 clear) reaches the accessing core's own registers. The remote window (bit 5 set) reaches the core named in the accessing core's remote-select register. Reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `local_irq_router`

## Requirements
- R1: After reset, every core has pending, mask and map-enable cleared, its control register reads 0xF, its remote-select register reads 0, all pins are low and the active index reads 7.
- R2: A one-cycle pulse on a core's hardware input k (0 watchdog, 1 compare, 2 timer, 3 performance counter, 4 debug channel) sets pending bit k of that core. A write to offset 7 clears the hardware pending bits whose data bits [4:0] are one. A pulse in the same cycle as a clear leaves the bit set.
- R3: A write to offset 5 sets software pending bit 5 (data bit 0) and bit 6 (data bit 1), and clears them with data bits 2 and 3. When a set and a clear of the same bit meet, the clear wins.
- R4: A write to offset 4 sets the mask bits whose data bits [6:0] are one. A write to offset 3 clears them. Offset 2 reads the mask in bits [6:0] and offset 1 reads pending.
- R5: Each core's active index is the lowest bit number set in pending AND mask, or 7 when that set is empty.
- R6: The map register of source s sits at offset 8+s, with an enable in bit 31 and a pin number in bits [5:0]. A live source drives its mapped pin only while enable is set, and a pin number of NUM_PINS or more drives no pin. When several sources map to the same pin, their outputs are ORed.
- R7: Control register (offset 0) bit 0 makes the timer routable, bit 1 the performance counter, bit 2 the debug channel, and bit 3 both software interrupts. Watchdog and compare are always routable. A cleared flag keeps the source off every pin but does not change pending or the active index.
- R8: The remote-select register sits at offset 6 in the local window only. In the remote window, offset 6 reads 0 and ignores writes. Every other offset in the remote window reaches the selected core's registers.
- R9: When the accessing core index, or the remote-select value in use, is NUM_CORES or above, writes change nothing and reads return 0.
- R10: The write-only offsets 3, 4, 5 and 7, and unused offsets, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | NUM_CORES*5 | Hardware source pulses; bits [5c+4:5c] belong to core c |
| bus_we | input | 1 | Write strobe for the current access |
| bus_core | input | clog2(NUM_CORES) | Index of the accessing core |
| bus_addr | input | 6 | Bit 5 selects the window, bits [4:0] give the register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_pins | output | NUM_CORES*NUM_PINS | Pin vectors; bits [c*NUM_PINS+p] drive pin p of core c |
| irq_active | output | NUM_CORES*3 | Active source index per core, 7 when none |

## Verification
The bench builds the router with three cores and six pins. With three cores, the two-bit core index and remote-select fields can hold the value 3, which names no core, so the ignored-access and zero-read paths of R9 can be driven from the ports. Six pins leave pin codes 6 through 63 out of range, and random map writes hit them often. Directed sequences cover each requirement, and a long random phase then mixes pulses, both windows and map writes, while a behavioural model compares pins, active indices and read data every cycle.

// File: rtl/local_irq_router.sv
module local_irq_router #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_CORES*5-1:0] hw_evt,
  input  logic bus_we,
  input  logic [((NUM_CORES > 1) ? $clog2(NUM_CORES) : 1)-1:0] bus_core,
  input  logic [5:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_pins,
  output logic [NUM_CORES*3-1:0] irq_active
);
  localparam int NSRC = 7;
  localparam int NHW  = 5;
  localparam int CW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam logic [4:0] OFS_CTRL = 5'd0, OFS_PEND = 5'd1, OFS_MASK = 5'd2,
                         OFS_RMASK = 5'd3, OFS_SMASK = 5'd4, OFS_SWCTL = 5'd5,
                         OFS_OSEL = 5'd6, OFS_PCLR = 5'd7;

  logic [NUM_CORES-1:0][NSRC-1:0] pend, pend_nxt, mask, men, rout;
  logic [NUM_CORES-1:0][3:0] ctrl;
  logic [NUM_CORES-1:0][CW-1:0] oaddr;
  logic [NUM_CORES-1:0][NSRC-1:0][5:0] mpin;
  logic [NUM_CORES-1:0][2:0] act;
  logic [NUM_CORES-1:0][NUM_PINS-1:0] pins_v;

  logic other, core_ok, tgt_ok, wr, map_hit;
  logic [4:0] ofs;
  logic [2:0] msel;
  logic [CW-1:0] tgt;
  logic unused_wdata;

  assign other   = bus_addr[5];
  assign ofs     = bus_addr[4:0];
  assign msel    = ofs[2:0];
  assign map_hit = (ofs[4:3] == 2'b01) && (ofs[2:0] != 3'd7);
  assign core_ok = int'(bus_core) < NUM_CORES;
  assign tgt     = other ? oaddr[bus_core] : bus_core;
  assign tgt_ok  = core_ok && (!other || int'(oaddr[bus_core]) < NUM_CORES);
  assign wr      = bus_we && tgt_ok;
  assign unused_wdata = ^bus_wdata[30:7];

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      pend_nxt[c] = pend[c];
      if (wr && int'(tgt) == c) begin
        if (ofs == OFS_PCLR) pend_nxt[c][NHW-1:0] = pend[c][NHW-1:0] & ~bus_wdata[NHW-1:0];
        if (ofs == OFS_SWCTL) begin
          for (int k = 0; k < 2; k++) begin
            if (bus_wdata[2+k])    pend_nxt[c][NHW+k] = 1'b0;
            else if (bus_wdata[k]) pend_nxt[c][NHW+k] = 1'b1;
          end
        end
      end
      pend_nxt[c][NHW-1:0] = pend_nxt[c][NHW-1:0] | hw_evt[c*NHW +: NHW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; mask <= '0; men <= '0; mpin <= '0; oaddr <= '0;
      ctrl <= {NUM_CORES{4'hF}};
    end else begin
      pend <= pend_nxt;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (wr && int'(tgt) == c) begin
          case (ofs)
            OFS_CTRL:  ctrl[c] <= bus_wdata[3:0];
            OFS_RMASK: mask[c] <= mask[c] & ~bus_wdata[NSRC-1:0];
            OFS_SMASK: mask[c] <= mask[c] | bus_wdata[NSRC-1:0];
            OFS_OSEL:  if (!other) oaddr[c] <= bus_wdata[CW-1:0];
            default: ;
          endcase
          if (map_hit) begin
            men[c][msel]  <= bus_wdata[31];
            mpin[c][msel] <= bus_wdata[5:0];
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (tgt_ok) begin
      case (ofs)
        OFS_CTRL: bus_rdata[3:0]      = ctrl[tgt];
        OFS_PEND: bus_rdata[NSRC-1:0] = pend[tgt];
        OFS_MASK: bus_rdata[NSRC-1:0] = mask[tgt];
        OFS_OSEL: if (!other) bus_rdata[CW-1:0] = oaddr[tgt];
        default: ;
      endcase
      if (map_hit) bus_rdata = {men[tgt][msel], 25'd0, mpin[tgt][msel]};
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      rout[c] = {ctrl[c][3], ctrl[c][3], ctrl[c][2], ctrl[c][1], ctrl[c][0], 2'b11};
      act[c] = 3'd7;
      for (int s = NSRC - 1; s >= 0; s--)
        if (pend[c][s] && mask[c][s]) act[c] = 3'(s);
      pins_v[c] = '0;
      for (int s = 0; s < NSRC; s++)
        for (int p = 0; p < NUM_PINS; p++)
          if (pend[c][s] && mask[c][s] && rout[c][s] && men[c][s] && mpin[c][s] == 6'(p))
            pins_v[c][p] = 1'b1;
    end
  end

  assign irq_pins   = pins_v;
  assign irq_active = act;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      irq_active[c*3 +: 3] == 3'd7 |-> irq_pins[c*NUM_PINS +: NUM_PINS] == '0);
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[c*NHW +: NHW] != '0 |=>
        (pend[c][NHW-1:0] & $past(hw_evt[c*NHW +: NHW])) == $past(hw_evt[c*NHW +: NHW]));
    a_r4_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(tgt) == c && ofs == OFS_SMASK) |=>
        (mask[c] & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]));
    a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(tgt) == c && ofs == OFS_RMASK) |=>
        (mask[c] & $past(bus_wdata[NSRC-1:0])) == '0);
  end

  a_r9_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !tgt_ok) |=> ($stable(mask) && $stable(ctrl) && $stable(men) && $stable(oaddr)));
endmodule

// File: tb/local_irq_router_tb.sv
module local_irq_router_tb_top;
  localparam int NC = 3;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC*5-1:0] hw_evt = '0;
  logic bus_we = 1'b0;
  logic [1:0] bus_core = '0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC*NP-1:0] irq_pins;
  logic [NC*3-1:0] irq_active;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  local_irq_router #(.NUM_CORES(NC), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .bus_we(bus_we), .bus_core(bus_core),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pins(irq_pins), .irq_active(irq_active));

  bit [6:0] m_pend [NC];
  bit [6:0] m_mask [NC];
  bit [3:0] m_ctrl [NC];
  bit [1:0] m_osel [NC];
  bit       m_en   [NC][7];
  bit [5:0] m_pin  [NC][7];

  function automatic int target(int core, bit rem);
    if (core >= NC) return -1;
    if (!rem) return core;
    if (int'(m_osel[core]) >= NC) return -1;
    return int'(m_osel[core]);
  endfunction

  function automatic bit routable(int c, int s);
    case (s)
      2: return m_ctrl[c][0];
      3: return m_ctrl[c][1];
      4: return m_ctrl[c][2];
      5, 6: return m_ctrl[c][3];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [31:0] exp_rd();
    int t = target(int'(bus_core), bus_addr[5]);
    int o = int'(bus_addr[4:0]);
    if (t < 0) return 32'd0;
    if (o == 0) return {28'd0, m_ctrl[t]};
    if (o == 1) return {25'd0, m_pend[t]};
    if (o == 2) return {25'd0, m_mask[t]};
    if (o == 6) return bus_addr[5] ? 32'd0 : {30'd0, m_osel[t]};
    if (o >= 8 && o <= 14) return {m_en[t][o-8], 25'd0, m_pin[t][o-8]};
    return 32'd0;
  endfunction

  function automatic bit [NC*NP-1:0] exp_pins();
    bit [NC*NP-1:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 7; s++)
        if (m_pend[c][s] && m_mask[c][s] && routable(c, s) && m_en[c][s] && int'(m_pin[c][s]) < NP)
          v[c*NP + int'(m_pin[c][s])] = 1'b1;
    return v;
  endfunction

  function automatic bit [NC*3-1:0] exp_act();
    bit [NC*3-1:0] v;
    for (int c = 0; c < NC; c++) begin
      int a = 7;
      for (int s = 6; s >= 0; s--) if (m_pend[c][s] && m_mask[c][s]) a = s;
      v[c*3 +: 3] = 3'(a);
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_pend[c] = '0; m_mask[c] = '0; m_ctrl[c] = 4'hF; m_osel[c] = '0;
      for (int s = 0; s < 7; s++) begin m_en[c][s] = 1'b0; m_pin[c][s] = '0; end
    end
  endtask

  task automatic model_edge();
    int t = target(int'(bus_core), bus_addr[5]);
    int o = int'(bus_addr[4:0]);
    for (int c = 0; c < NC; c++) begin
      if (bus_we && t == c) begin
        if (o == 7) m_pend[c][4:0] = m_pend[c][4:0] & ~bus_wdata[4:0];
        if (o == 5)
          for (int k = 0; k < 2; k++)
            if (bus_wdata[2+k]) m_pend[c][5+k] = 1'b0;
            else if (bus_wdata[k]) m_pend[c][5+k] = 1'b1;
      end
      m_pend[c][4:0] = m_pend[c][4:0] | hw_evt[c*5 +: 5];
    end
    if (bus_we && t >= 0) begin
      if (o == 0) m_ctrl[t] = bus_wdata[3:0];
      if (o == 3) m_mask[t] = m_mask[t] & ~bus_wdata[6:0];
      if (o == 4) m_mask[t] = m_mask[t] | bus_wdata[6:0];
      if (o == 6 && !bus_addr[5]) m_osel[t] = bus_wdata[1:0];
      if (o >= 8 && o <= 14) begin m_en[t][o-8] = bus_wdata[31]; m_pin[t][o-8] = bus_wdata[5:0]; end
    end
  endtask

  task automatic check(string tag, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "pins", 32'(irq_pins), 32'(exp_pins()));
    check(tag, "active", 32'(irq_active), 32'(exp_act()));
    check(tag, "rdata", bus_rdata, exp_rd());
  endtask

  task automatic step(bit we, int core, bit [5:0] addr, bit [31:0] data, bit [NC*5-1:0] hw, string tag);
    @(negedge clk);
    bus_we = we; bus_core = 2'(core); bus_addr = addr; bus_wdata = data; hw_evt = hw;
    #1;
    compare(tag);
    model_edge();
  endtask

  task automatic wr(int core, bit [5:0] addr, bit [31:0] data, string tag);
    step(1'b1, core, addr, data, '0, tag);
  endtask

  task automatic rd(int core, bit [5:0] addr, string tag);
    step(1'b0, core, addr, 32'd0, '0, tag);
  endtask

  initial begin
    #(150_000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every core and register
    for (int c = 0; c < NC; c++) begin
      rd(c, 6'd0, "R1"); rd(c, 6'd1, "R1"); rd(c, 6'd2, "R1"); rd(c, 6'd6, "R1"); rd(c, 6'd10, "R1");
    end
    // R2: hardware pulses and clear precedence
    for (int k = 0; k < 5; k++) step(1'b0, 0, 6'd1, 0, 15'(1 << k), "R2");
    rd(0, 6'd1, "R2");
    wr(0, 6'd7, 32'h05, "R2");
    rd(0, 6'd1, "R2");
    step(1'b1, 0, 6'd7, 32'h1F, 15'h0008, "R2");
    rd(0, 6'd1, "R2");
    step(1'b0, 1, 6'd1, 0, 15'h0020, "R2");
    rd(1, 6'd1, "R2");
    // R4: mask set and clear
    wr(0, 6'd4, 32'h7F, "R4"); rd(0, 6'd2, "R4");
    wr(0, 6'd3, 32'h09, "R4"); rd(0, 6'd2, "R4");
    wr(0, 6'd4, 32'h09, "R4");
    // R3: software pending set, clear, clear wins
    wr(0, 6'd5, 32'h3, "R3"); rd(0, 6'd1, "R3");
    wr(0, 6'd5, 32'h4, "R3"); rd(0, 6'd1, "R3");
    wr(0, 6'd5, 32'hA, "R3"); rd(0, 6'd1, "R3");
    // R5: active index walks up as bits clear
    wr(0, 6'd7, 32'h1F, "R5"); rd(0, 6'd1, "R5");
    wr(0, 6'd5, 32'h3, "R5"); rd(0, 6'd1, "R5");
    step(1'b0, 0, 6'd1, 0, 15'h0014, "R5");
    wr(0, 6'd7, 32'h04, "R5"); rd(0, 6'd1, "R5");
    wr(0, 6'd3, 32'h10, "R5"); rd(0, 6'd1, "R5");
    wr(0, 6'd5, 32'h4, "R5"); wr(0, 6'd5, 32'h8, "R5"); rd(0, 6'd1, "R5");
    // R6: pin mapping, enable, out-of-range pin, OR of sources
    wr(1, 6'd4, 32'h7F, "R6");
    wr(1, 6'd10, 32'h8000_0003, "R6");
    step(1'b0, 1, 6'd10, 0, 15'h0020 << 2, "R6");
    rd(1, 6'd10, "R6");
    wr(1, 6'd8, 32'h8000_0003, "R6");
    step(1'b0, 1, 6'd8, 0, 15'h0020, "R6");
    wr(1, 6'd10, 32'h0000_0003, "R6"); rd(1, 6'd10, "R6");
    wr(1, 6'd8, 32'h8000_0007, "R6"); rd(1, 6'd8, "R6");
    wr(1, 6'd8, 32'h8000_0005, "R6"); rd(1, 6'd8, "R6");
    // R7: routability flags gate pins only
    wr(1, 6'd10, 32'h8000_0001, "R7"); rd(1, 6'd0, "R7");
    wr(1, 6'd0, 32'hE, "R7"); rd(1, 6'd0, "R7");
    wr(1, 6'd0, 32'h7, "R7");
    wr(1, 6'd13, 32'h8000_0002, "R7"); wr(1, 6'd5, 32'h1, "R7"); rd(1, 6'd1, "R7");
    wr(1, 6'd0, 32'hF, "R7"); rd(1, 6'd0, "R7");
    // R8: remote window
    wr(0, 6'd6, 32'h2, "R8"); rd(0, 6'd6, "R8");
    wr(0, 6'd36, 32'h41, "R8"); rd(2, 6'd2, "R8"); rd(0, 6'd34, "R8");
    rd(0, 6'd38, "R8"); wr(0, 6'd38, 32'h1, "R8"); rd(0, 6'd6, "R8"); rd(2, 6'd6, "R8");
    wr(0, 6'd40, 32'h8000_0004, "R8"); step(1'b0, 2, 6'd8, 0, 15'h0400, "R8");
    // R9: out-of-range core or remote select
    wr(0, 6'd6, 32'h3, "R9"); wr(0, 6'd36, 32'h7F, "R9"); rd(0, 6'd34, "R9");
    wr(3, 6'd4, 32'h7F, "R9"); rd(3, 6'd0, "R9"); wr(3, 6'd0, 32'h0, "R9");
    for (int c = 0; c < NC; c++) rd(c, 6'd2, "R9");
    // R10: write-only and unused offsets read zero
    foreach (m_ctrl[c]) begin
      rd(c, 6'd3, "R10"); rd(c, 6'd4, "R10"); rd(c, 6'd5, "R10"); rd(c, 6'd7, "R10");
      rd(c, 6'd15, "R10"); rd(c, 6'd20, "R10");
    end
    // random mix, compared every cycle against the model for R5 R6 R8
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] r = $urandom;
      bit [31:0] d = $urandom;
      bit [NC*5-1:0] h = ((r[3:0] == 0) ? 15'($urandom) : '0);
      bit [5:0] a = {r[4], (r[6:5] == 0) ? 5'(8 + (r[9:7] % 7)) : 5'(r[12:8] % 16)};
      if (a[4:0] >= 8 && a[4:0] <= 14) d = {d[31], 25'd0, 3'd0, d[2:0]};
      if (a[4:0] == 6) d = 32'(r[14:13] % 4);
      if (a[4:0] == 6 && r[15:13] != 0) d = 32'(r[15] ? 1 : 2);
      step(r[20] || r[21], (r[23:22] == 3) ? 3 : int'(r[23:22]), a, d, h, "R6");
    end
    rd(0, 6'd1, "R5");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule